// File: doc/BRIEF.md
# Ownership-Tracking Snooping Cache Line Controller

This block keeps one small direct-mapped, write-back cache coherent with its peers on a shared snooping bus under a write-invalidate policy. Every line is in one of four states: Invalid, Valid (a clean copy that others may also hold), Shared Dirty (modified, other clean copies may exist, this cache owns it) or Exclusive Dirty (modified, no other copy, this cache owns it). A cache that holds a line in one of the two dirty states is the owner of that line. When no cache owns a line, memory is the owner. On any miss the owner supplies the data, so modified data moves from cache to cache without first going to memory.

The processor side presents one read or write at a time and holds it until a one-cycle ready pulse. The bus side issues read, read-for-ownership, invalidate and write-back transactions, each held until the responder pulses done. The same four transactions from other caches are snooped. The response is combinational in the snoop cycle: a hit flag, an owner-supply flag and the supplied data. The state change takes effect at the next clock edge.

Top module: `coh_own_cache`

## Requirements
- R1: After reset every line is Invalid. `cpu_ready` and `bus_req` are low, a snoop of any address gets no supply, and the first access to any address misses.
- R2: A read miss issues a bus read (bus command code 0) and fills the line as Valid. Every processor read returns the most recently written value of the address, whether the owner is memory or another cache. `cpu_ready` is a single-cycle pulse.
- R3: A write miss issues a read-for-ownership (code 1) and leaves the line Exclusive Dirty. A write hit on an Exclusive Dirty line completes with no bus transaction.
- R4: A write hit on a Valid or Shared Dirty line issues an invalidate (code 2), and the line then becomes Exclusive Dirty.
- R5: A snooped read of an owned line asserts `snp_supply` with the current data. Exclusive Dirty becomes Shared Dirty, ownership stays local, and no write-back goes to memory.
- R6: A snooped read-for-ownership or invalidate moves a matching local copy to Invalid. An owned copy supplies its data first on a read-for-ownership; an invalidate needs no supply. A snooped write-back (code 3) changes nothing.
- R7: The line index is the low log2(DEPTH) address bits. A miss whose victim is owned first writes the victim back (code 3) with its address and data. A Valid victim is dropped with no bus transaction.
- R8: If a snoop removes the line while its invalidate is still waiting for done, the controller withdraws the invalidate and issues a read-for-ownership for the same address.
- R9: `snp_supply` rises only for an owned line that matches the snooped address, so an address never has two owners. A snoop that misses gets no supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Single-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| bus_req | output | 1 | Bus transaction request |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_done | input | 1 | Responder completes the current transaction |
| bus_rdata | input | DATA_W | Fill data returned with bus_done |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, same codes as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_hit | output | 1 | A valid local copy matches |
| snp_supply | output | 1 | This cache supplies the line as owner |
| snp_data | output | DATA_W | Supplied data |

## Verification
The bench models memory and the remote caches, and it tracks which address the block should own. A design that kept Exclusive Dirty on a snooped read, or that wrote it back, is caught by the next write hit issuing no invalidate, or by a write-back arriving for a line the model says is shared. A design that issued read-for-ownership on write hits, or that upgraded silently, shows up in the bus command counts. The bench stalls an invalidate and snoops it away to check that the upgrade is reissued as read-for-ownership. Evictions against a conflicting index catch a missing write-back, which leaves stale data, and a spurious one, which reports a write-back for an address the block did not own.

// File: rtl/coh_own_pkg.sv
`timescale 1ns/1ps
package coh_own_pkg;

  typedef enum logic [1:0] {
    LS_INV    = 2'd0,
    LS_VALID  = 2'd1,
    LS_SDIRTY = 2'd2,
    LS_EDIRTY = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_READ = 2'd0,
    BC_RFO  = 2'd1,
    BC_INV  = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    FS_IDLE = 3'd0,
    FS_WB   = 3'd1,
    FS_FILL = 3'd2,
    FS_UPG  = 3'd3,
    FS_RESP = 3'd4
  } fsm_st_e;

  // ownership lives with the dirty states
  function automatic logic st_owner(line_st_e s);
    return (s == LS_SDIRTY) || (s == LS_EDIRTY);
  endfunction

  // state a matching line takes after a snooped command
  function automatic line_st_e snoop_next(line_st_e s, bus_cmd_e c);
    line_st_e n;
    case (c)
      BC_READ:        n = (s == LS_EDIRTY) ? LS_SDIRTY : s;
      BC_RFO, BC_INV: n = LS_INV;
      default:        n = s;
    endcase
    return n;
  endfunction

  // owner hands data to a requester that needs it
  function automatic logic snoop_supplies(line_st_e s, bus_cmd_e c);
    return st_owner(s) && ((c == BC_READ) || (c == BC_RFO));
  endfunction

  // write hit that must first remove other copies
  function automatic logic write_needs_upgrade(line_st_e s);
    return (s == LS_VALID) || (s == LS_SDIRTY);
  endfunction

endpackage

// File: rtl/coh_line_array.sv
`timescale 1ns/1ps
module coh_line_array
  import coh_own_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fill_we,
  input  logic [IDX_W-1:0]              fill_idx,
  input  logic [TAG_W-1:0]              fill_tag,
  input  logic [DATA_W-1:0]             fill_data,
  input  logic [1:0]                    fill_st,
  input  logic                          snp_we,
  input  logic [IDX_W-1:0]              snp_idx,
  input  logic [1:0]                    snp_st,
  output logic [DEPTH-1:0][1:0]         st_q,
  output logic [DEPTH-1:0][TAG_W-1:0]   tag_q,
  output logic [DEPTH-1:0][DATA_W-1:0]  data_q
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    logic [1:0]        st_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] dat_r;
    logic              sel_fill;
    logic              sel_snp;

    assign sel_fill = fill_we && (fill_idx == IDX_W'(i));
    assign sel_snp  = snp_we  && (snp_idx  == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= LS_INV;
        tag_r <= '0;
        dat_r <= '0;
      end else begin
        if (sel_snp)       st_r <= snp_st;
        else if (sel_fill) st_r <= fill_st;
        if (sel_fill) begin
          tag_r <= fill_tag;
          dat_r <= fill_data;
        end
      end
    end

    assign st_q[i]   = st_r;
    assign tag_q[i]  = tag_r;
    assign data_q[i] = dat_r;
  end

endmodule

// File: rtl/coh_snoop_unit.sv
`timescale 1ns/1ps
module coh_snoop_unit
  import coh_own_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic                          snp_valid,
  input  logic [1:0]                    snp_cmd,
  input  logic [ADDR_W-1:0]             snp_addr,
  input  logic [DEPTH-1:0][1:0]         st_q,
  input  logic [DEPTH-1:0][TAG_W-1:0]   tag_q,
  input  logic [DEPTH-1:0][DATA_W-1:0]  data_q,
  output logic                          snp_hit,
  output logic                          snp_supply,
  output logic [DATA_W-1:0]             snp_data,
  output logic                          upd_we,
  output logic [IDX_W-1:0]              upd_idx,
  output logic [1:0]                    upd_st
);

  logic [TAG_W-1:0] s_tag;
  line_st_e         s_cur;
  line_st_e         s_nxt;
  bus_cmd_e         s_cmd;

  assign upd_idx = snp_addr[IDX_W-1:0];
  assign s_tag   = snp_addr[ADDR_W-1:IDX_W];
  assign s_cur   = line_st_e'(st_q[upd_idx]);
  assign s_cmd   = bus_cmd_e'(snp_cmd);
  assign s_nxt   = snoop_next(s_cur, s_cmd);

  assign snp_hit    = snp_valid && (s_cur != LS_INV) && (tag_q[upd_idx] == s_tag);
  assign snp_supply = snp_hit && snoop_supplies(s_cur, s_cmd);
  assign snp_data   = snp_supply ? data_q[upd_idx] : '0;
  assign upd_we     = snp_hit && (s_nxt != s_cur);
  assign upd_st     = s_nxt;

endmodule

// File: rtl/coh_miss_fsm.sv
`timescale 1ns/1ps
module coh_miss_fsm
  import coh_own_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_req,
  input  logic                          cpu_we,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [DATA_W-1:0]             cpu_wdata,
  output logic                          cpu_ready,
  output logic [DATA_W-1:0]             cpu_rdata,
  input  logic                          snp_valid,
  output logic                          bus_req,
  output logic [1:0]                    bus_cmd,
  output logic [ADDR_W-1:0]             bus_addr,
  output logic [DATA_W-1:0]             bus_wdata,
  input  logic                          bus_done,
  input  logic [DATA_W-1:0]             bus_rdata,
  input  logic [DEPTH-1:0][1:0]         st_q,
  input  logic [DEPTH-1:0][TAG_W-1:0]   tag_q,
  input  logic [DEPTH-1:0][DATA_W-1:0]  data_q,
  output logic                          fill_we,
  output logic [IDX_W-1:0]              fill_idx,
  output logic [TAG_W-1:0]              fill_tag,
  output logic [DATA_W-1:0]             fill_data,
  output logic [1:0]                    fill_st,
  output logic                          ev_upg_lost,
  output logic                          ev_victim_owned
);

  fsm_st_e          cur, nxt;
  bus_cmd_e         cmd;
  line_st_e         fst;
  line_st_e         cur_st;
  logic [TAG_W-1:0] ctag, cur_tag;
  logic [DATA_W-1:0] cur_dat;
  logic             cpu_hit;

  assign fill_idx = cpu_addr[IDX_W-1:0];
  assign ctag     = cpu_addr[ADDR_W-1:IDX_W];
  assign cur_st   = line_st_e'(st_q[fill_idx]);
  assign cur_tag  = tag_q[fill_idx];
  assign cur_dat  = data_q[fill_idx];
  assign cpu_hit  = (cur_st != LS_INV) && (cur_tag == ctag);
  assign ev_victim_owned = st_owner(cur_st) && (cur_tag != ctag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= FS_IDLE;
    else        cur <= nxt;
  end

  always_comb begin
    nxt         = cur;
    cpu_ready   = 1'b0;
    cpu_rdata   = '0;
    bus_req     = 1'b0;
    cmd         = BC_READ;
    bus_addr    = cpu_addr;
    bus_wdata   = '0;
    fill_we     = 1'b0;
    fill_tag    = ctag;
    fill_data   = cur_dat;
    fst         = LS_INV;
    ev_upg_lost = 1'b0;
    case (cur)
      FS_IDLE: begin
        if (cpu_req && !snp_valid) begin
          if (cpu_hit) begin
            if (!cpu_we) begin
              nxt = FS_RESP;
            end else if (write_needs_upgrade(cur_st)) begin
              nxt = FS_UPG;
            end else begin
              fill_we   = 1'b1;
              fill_data = cpu_wdata;
              fst       = LS_EDIRTY;
              nxt       = FS_RESP;
            end
          end else if (ev_victim_owned) begin
            nxt = FS_WB;
          end else begin
            nxt = FS_FILL;
          end
        end
      end
      FS_WB: begin
        if (ev_victim_owned) begin
          bus_req   = 1'b1;
          cmd       = BC_WB;
          bus_addr  = {cur_tag, fill_idx};
          bus_wdata = cur_dat;
          if (bus_done) begin
            fill_we  = 1'b1;
            fill_tag = cur_tag;
            fst      = LS_INV;
            nxt      = FS_FILL;
          end
        end else begin
          nxt = FS_FILL;
        end
      end
      FS_FILL: begin
        bus_req = 1'b1;
        cmd     = cpu_we ? BC_RFO : BC_READ;
        if (bus_done) begin
          fill_we   = 1'b1;
          fill_data = cpu_we ? cpu_wdata : bus_rdata;
          fst       = cpu_we ? LS_EDIRTY : LS_VALID;
          nxt       = FS_RESP;
        end
      end
      FS_UPG: begin
        if (cpu_hit) begin
          bus_req = 1'b1;
          cmd     = BC_INV;
          if (bus_done) begin
            fill_we   = 1'b1;
            fill_data = cpu_wdata;
            fst       = LS_EDIRTY;
            nxt       = FS_RESP;
          end
        end else begin
          ev_upg_lost = 1'b1;
          nxt         = FS_FILL;
        end
      end
      FS_RESP: begin
        cpu_ready = 1'b1;
        cpu_rdata = cur_dat;
        nxt       = FS_IDLE;
      end
      default: nxt = FS_IDLE;
    endcase
  end

  assign bus_cmd = cmd;
  assign fill_st = fst;

endmodule

// File: rtl/coh_own_cache.sv
`timescale 1ns/1ps
module coh_own_cache
  import coh_own_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);

  logic [DEPTH-1:0][1:0]        st_q;
  logic [DEPTH-1:0][TAG_W-1:0]  tag_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;
  logic                         fill_we;
  logic [IDX_W-1:0]             fill_idx;
  logic [TAG_W-1:0]             fill_tag;
  logic [DATA_W-1:0]            fill_data;
  logic [1:0]                   fill_st;
  logic                         upd_we;
  logic [IDX_W-1:0]             upd_idx;
  logic [1:0]                   upd_st;
  logic                         ev_upg_lost;
  logic                         ev_victim_owned;
  logic [DEPTH-1:0]             valid_vec;
  logic [DEPTH-1:0]             owned_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_flags
    assign valid_vec[i] = (line_st_e'(st_q[i]) != LS_INV);
    assign owned_vec[i] = st_owner(line_st_e'(st_q[i]));
  end

  coh_line_array #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_we   (fill_we),
    .fill_idx  (fill_idx),
    .fill_tag  (fill_tag),
    .fill_data (fill_data),
    .fill_st   (fill_st),
    .snp_we    (upd_we),
    .snp_idx   (upd_idx),
    .snp_st    (upd_st),
    .st_q      (st_q),
    .tag_q     (tag_q),
    .data_q    (data_q)
  );

  coh_snoop_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_snoop (
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .snp_addr   (snp_addr),
    .st_q       (st_q),
    .tag_q      (tag_q),
    .data_q     (data_q),
    .snp_hit    (snp_hit),
    .snp_supply (snp_supply),
    .snp_data   (snp_data),
    .upd_we     (upd_we),
    .upd_idx    (upd_idx),
    .upd_st     (upd_st)
  );

  coh_miss_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_req         (cpu_req),
    .cpu_we          (cpu_we),
    .cpu_addr        (cpu_addr),
    .cpu_wdata       (cpu_wdata),
    .cpu_ready       (cpu_ready),
    .cpu_rdata       (cpu_rdata),
    .snp_valid       (snp_valid),
    .bus_req         (bus_req),
    .bus_cmd         (bus_cmd),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_done        (bus_done),
    .bus_rdata       (bus_rdata),
    .st_q            (st_q),
    .tag_q           (tag_q),
    .data_q          (data_q),
    .fill_we         (fill_we),
    .fill_idx        (fill_idx),
    .fill_tag        (fill_tag),
    .fill_data       (fill_data),
    .fill_st         (fill_st),
    .ev_upg_lost     (ev_upg_lost),
    .ev_victim_owned (ev_victim_owned)
  );

endmodule

// File: rtl/coh_own_cache_chk.sv
`timescale 1ns/1ps
module coh_own_cache_chk #(
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             snp_valid,
  input logic [1:0]       snp_cmd,
  input logic [IDX_W-1:0] snp_idx,
  input logic             snp_hit,
  input logic             snp_supply,
  input logic             cpu_ready,
  input logic             bus_req,
  input logic [1:0]       bus_cmd,
  input logic [IDX_W-1:0] bus_idx,
  input logic             bus_done,
  input logic             ev_upg_lost,
  input logic [DEPTH-1:0] valid_vec,
  input logic [DEPTH-1:0] owned_vec
);

  p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  p_owner_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == 2'd0 && snp_supply && !bus_done) |=> owned_vec[$past(snp_idx)]);

  p_snoop_kill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2) && snp_hit && !bus_done)
      |=> !valid_vec[$past(snp_idx)]);

  p_wb_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == 2'd3 && bus_done && !snp_valid) |=> !valid_vec[$past(bus_idx)]);

  p_upg_reissue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_upg_lost |=> (bus_req && bus_cmd == 2'd1));

  p_supply_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_hit && (snp_cmd == 2'd0 || snp_cmd == 2'd1)));

endmodule

bind coh_own_cache coh_own_cache_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .snp_valid   (snp_valid),
  .snp_cmd     (snp_cmd),
  .snp_idx     (snp_addr[IDX_W-1:0]),
  .snp_hit     (snp_hit),
  .snp_supply  (snp_supply),
  .cpu_ready   (cpu_ready),
  .bus_req     (bus_req),
  .bus_cmd     (bus_cmd),
  .bus_idx     (bus_addr[IDX_W-1:0]),
  .bus_done    (bus_done),
  .ev_upg_lost (ev_upg_lost),
  .valid_vec   (valid_vec),
  .owned_vec   (owned_vec)
);

// File: tb/coh_own_cache_tb.sv
`timescale 1ns/1ps
module coh_own_cache_tb_top;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_done = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_hit, snp_supply;
  logic [DW-1:0] snp_data;

  always #5 clk = ~clk;

  coh_own_cache #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_hit(snp_hit), .snp_supply(snp_supply), .snp_data(snp_data)
  );

  // bench model: memory, remote owner copies, latest value, expected local ownership
  logic [DW-1:0] mem [256];
  logic [DW-1:0] rval [256];
  logic [DW-1:0] gold [256];
  bit            rown [256];
  bit            down [256];
  int n_chk = 0, n_fail = 0;
  int n_rd = 0, n_rfo = 0, n_inv = 0, n_wb = 0;
  bit bus_hold = 1'b0;
  logic [AW-1:0] ra;

  typedef struct { bit rd; logic [DW-1:0] d; string rq; } exp_t;
  exp_t sb_q[$];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // bus responder: memory plus remote caches
  always @(negedge clk) begin
    if (bus_done) begin
      bus_done = 1'b0;
    end else if (rst_n && bus_req && !bus_hold) begin
      ra = bus_addr;
      case (bus_cmd)
        2'd0: begin n_rd++;  bus_rdata = rown[ra] ? rval[ra] : mem[ra]; end
        2'd1: begin n_rfo++; bus_rdata = rown[ra] ? rval[ra] : mem[ra]; rown[ra] = 1'b0; end
        2'd2: begin n_inv++; rown[ra] = 1'b0; end
        default: begin
          n_wb++;
          chk(down[ra], "R7 write-back only of an owned line", 32'(down[ra]), 1);
          chk(!rown[ra], "R9 single owner at write-back", 32'(rown[ra]), 0);
          chk(bus_wdata == gold[ra], "R7 write-back data", bus_wdata, gold[ra]);
          mem[ra] = bus_wdata;
          down[ra] = 1'b0;
        end
      endcase
      bus_done = 1'b1;
    end
  end

  // monitor: pops the scoreboard on each completion
  always @(negedge clk) begin
    if (rst_n && cpu_ready) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R2 unexpected ready", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.rd) chk(cpu_rdata == e.d, e.rq, cpu_rdata, e.d);
      end
    end
  end

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input string rq);
    exp_t e;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    e.rd = !we; e.d = gold[a]; e.rq = rq;
    sb_q.push_back(e);
    do @(negedge clk); while (!cpu_ready);
    cpu_req = 1'b0;
    if (we) begin gold[a] = d; down[a] = 1'b1; end
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input string rq);
    bit exp_sup;
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    #1;
    exp_sup = down[a] && (c == 2'd0 || c == 2'd1);
    chk(snp_supply == exp_sup, rq, 32'(snp_supply), 32'(exp_sup));
    if (snp_supply) begin
      chk(snp_data == gold[a], rq, snp_data, gold[a]);
      chk(!rown[a], "R9 two owners", 32'(rown[a]), 0);
    end
    @(negedge clk);
    snp_valid = 1'b0;
    if (c == 2'd1 || c == 2'd2) down[a] = 1'b0;
  endtask

  task automatic remote_write(input logic [AW-1:0] a, input logic [DW-1:0] v, input string rq);
    snoop(2'd1, a, rq);
    rown[a] = 1'b1; rval[a] = v; gold[a] = v;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int s_rd, s_rfo, s_inv, s_wb;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'h1000 + 16'(i * 3);
      gold[i] = mem[i]; rval[i] = '0; rown[i] = 1'b0; down[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset, nothing owned
    chk(!cpu_ready && !bus_req, "R1 idle outputs", {cpu_ready, bus_req}, 0);
    snoop(2'd0, 8'h10, "R1 no supply after reset");
    chk(!snp_hit, "R1 no hit after reset", 32'(snp_hit), 0);

    // R2: read miss then read hit
    s_rd = n_rd;
    cpu_op(0, 8'h10, 0, "R2 read miss data");
    chk(n_rd == s_rd + 1, "R1 first access misses (R2 read cmd)", n_rd, s_rd + 1);
    cpu_op(0, 8'h10, 0, "R2 read hit data");
    chk(n_rd == s_rd + 1, "R2 hit issues nothing", n_rd, s_rd + 1);

    // R4: write hit on Valid -> invalidate
    s_inv = n_inv; s_rfo = n_rfo;
    cpu_op(1, 8'h10, 16'hA1A1, "R4");
    chk(n_inv == s_inv + 1 && n_rfo == s_rfo, "R4 upgrade uses invalidate", n_inv, s_inv + 1);

    // R3: write hit on Exclusive Dirty is silent
    s_rd = n_rd; s_rfo = n_rfo; s_inv = n_inv; s_wb = n_wb;
    cpu_op(1, 8'h10, 16'hA1A2, "R3");
    chk(n_rd + n_rfo + n_inv + n_wb == s_rd + s_rfo + s_inv + s_wb, "R3 silent write hit",
        n_rd + n_rfo + n_inv + n_wb, s_rd + s_rfo + s_inv + s_wb);
    cpu_op(0, 8'h10, 0, "R3 read back");

    // R5: snooped read of owned line: supply, keep ownership, memory untouched
    s_wb = n_wb;
    snoop(2'd0, 8'h10, "R5 supply on snooped read");
    chk(n_wb == s_wb && mem[8'h10] != gold[8'h10], "R5 memory not updated", mem[8'h10], 16'h1030);
    snoop(2'd0, 8'h10, "R5 shared dirty still supplies");
    s_inv = n_inv;
    cpu_op(1, 8'h10, 16'hA1A3, "R4 write hit shared dirty");
    chk(n_inv == s_inv + 1, "R4 shared dirty upgrade", n_inv, s_inv + 1);

    // R6: snooped write-back ignored, RFO takes line with supply, INV kills clean copy
    snoop(2'd3, 8'h10, "R6 write-back snoop no supply");
    snoop(2'd0, 8'h10, "R6 line unchanged after write-back snoop");
    remote_write(8'h10, 16'hB1B1, "R6 supply before losing line");
    s_rd = n_rd;
    cpu_op(0, 8'h10, 0, "R2 cache-to-cache data");
    chk(n_rd == s_rd + 1, "R6 copy was invalidated", n_rd, s_rd + 1);
    snoop(2'd2, 8'h10, "R6 invalidate no supply");
    s_rd = n_rd;
    cpu_op(0, 8'h10, 0, "R6 data after invalidate");
    chk(n_rd == s_rd + 1, "R6 invalidate removed copy", n_rd, s_rd + 1);

    // R7: conflicting index 0: Valid victim silent, owned victim written back
    s_wb = n_wb; s_rfo = n_rfo;
    cpu_op(1, 8'h24, 16'hC1C1, "R3 write miss");
    chk(n_rfo == s_rfo + 1, "R3 write miss uses RFO", n_rfo, s_rfo + 1);
    chk(n_wb == s_wb, "R7 valid victim silent", n_wb, s_wb);
    cpu_op(0, 8'h30, 0, "R7 read after eviction");
    chk(n_wb == s_wb + 1, "R7 owned victim written back", n_wb, s_wb + 1);
    chk(mem[8'h24] == 16'hC1C1, "R7 memory holds victim", mem[8'h24], 16'hC1C1);
    cpu_op(0, 8'h24, 0, "R7 refetch from memory");

    // R8: upgrade lost to a snoop is reissued as RFO
    cpu_op(0, 8'h31, 0, "R8 setup read");
    bus_hold = 1'b1;
    fork
      cpu_op(1, 8'h31, 16'hD1D1, "R8");
    join_none
    for (int k = 0; k < 40 && !(bus_req && bus_cmd == 2'd2); k++) @(negedge clk);
    chk(bus_req && bus_cmd == 2'd2, "R8 invalidate pending", bus_cmd, 2);
    remote_write(8'h31, 16'hE1E1, "R8 snoop on clean copy");
    for (int k = 0; k < 40 && !(bus_req && bus_cmd == 2'd1); k++) @(negedge clk);
    chk(bus_req && bus_cmd == 2'd1, "R8 reissued as RFO", bus_cmd, 1);
    bus_hold = 1'b0;
    wait fork;
    cpu_op(0, 8'h31, 0, "R8 own write wins");
    snoop(2'd0, 8'h31, "R9 supply after race");

    // R9: mixed traffic, single owner, no supply on a miss
    snoop(2'd0, 8'hF7, "R9 snoop miss no supply");
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a;
      a = 8'h40 + AW'(i * 5);
      cpu_op(1, a, 16'h5000 + 16'(i), "R9 mixed write");
      snoop(2'd0, a, "R9 mixed remote read");
      remote_write(a, 16'h6000 + 16'(i), "R9 mixed remote write");
      cpu_op(0, a, 0, "R9 mixed read");
      cpu_op(1, a, 16'h7000 + 16'(i), "R9 mixed rewrite");
      snoop(2'd1, a, "R9 mixed takeover");
    end
    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R2 all completions seen", sb_q.size(), 0);
    summary();
    $finish;
  end

endmodule